// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the SDRAM command pins from reset. First it runs the start-up sequence the memory requires. The sequence opens with a long stretch of NOP commands, with clock-enable and the data masks held high. A precharge of every bank follows, then a fixed number of auto-refresh commands, then one mode register load. After the load the block waits out the register's settle time and raises `init_done`.

From then on, an interval counter adds one owed refresh every `REF_INTERVAL` cycles. The interval comes from the row count and the retention period, so that every row is refreshed in time. The count of owed refreshes saturates at eight.

A user controller asks for the bus with `usr_req` and may drive commands while `usr_gnt` is high. During that time this block drives NOP, so an outside multiplexer can select the user's path. A grant is only given when nothing is owed. A user that holds `usr_busy` keeps its grant even while refreshes build up. Once the bus is free and refreshes are owed, the block precharges all banks and issues every owed refresh back to back, each spaced by the refresh cycle time. All timing values are parameters given in ns or µs, together with the clock frequency.

Top module: `sdram_init_refresh`

## Requirements
- R1: Command encoding is {cs_n, ras_n, cas_n, we_n}: NOP=0111, precharge=0010, auto-refresh=0001, mode load=0000. While `init_done` is low, `sd_cke` is 1 and every `sd_dqm` bit is 1. After reset is released, only NOP is driven for at least `T_POWERUP_US`×`CLK_MHZ` cycles (20000 by default).
- R2: The first command after the power-up wait is a precharge with address bit 10 set, which selects all banks.
- R3: After that precharge come exactly `INIT_REFRESHES` (default 2) auto-refresh commands. The first follows the precharge by at least the precharge time in cycles (2 by default). Each later one follows the previous refresh by at least the refresh cycle time in cycles (7 by default).
- R4: The next command is one mode load with bank address 0. It carries the burst length code on address bits 2..0 and the burst type on bit 3. The CAS latency is on bits 6..4, and bits 8..7 are 0. The write-burst mode is on bit 9, and bits 11..10 are 0. The default value is 12'h033.
- R5: The two cycles after the mode load carry NOP. `init_done` rises in the second of those cycles and stays high until reset.
- R6: After `init_done`, one refresh is owed every `REF_INTERVAL` cycles. An owed refresh is served, when no grant is held, by a precharge-all followed by an auto-refresh. A single owed refresh produces exactly one auto-refresh.
- R7: Any two auto-refresh commands are at least the refresh cycle time apart. A precharge comes at least the precharge time before the next auto-refresh.
- R8: The owed count saturates at 8. A user that holds the bus for more than eight intervals is followed by exactly eight back-to-back refreshes after one precharge-all.
- R9: `usr_gnt` rises only when `init_done` is high and no refresh is owed. It rises one cycle after `usr_req` when the block is idle. It stays high while `usr_req` and `usr_busy` are both high. It drops one cycle after `usr_busy` falls if a refresh is owed.
- R10: While `usr_gnt` is high, the block drives NOP.
- R11: `usr_gnt` falls one cycle after `usr_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_req | input | 1 | User asks for the command bus |
| usr_busy | input | 1 | User is mid-transaction; grant must not be revoked |
| usr_gnt | output | 1 | User may drive the bus |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins (bit 10 selects all banks on precharge) |
| sd_ba | output | BA_W | Bank address |
| sd_dqm | output | DQM_W | Data masks, high during initialization |
| init_done | output | 1 | Start-up sequence and settle time complete |

## Verification
The hardest state to reach is the saturated backlog. It needs a user that holds the bus through more than eight refresh intervals, and then a release that lands away from a new interval tick, so that the drain count is exact. The stimulus first waits for a periodic refresh to fix the phase of the interval counter. It then requests with `usr_busy` high for nine intervals, checks every cycle that the grant holds and the bus stays NOP, and finally drops `usr_busy`. It then counts precharges and refreshes, and the spacing between them, until the grant comes back.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        ST_PWR,
        ST_IPRE,
        ST_IREF,
        ST_IMRS,
        ST_SETTLE,
        ST_IDLE,
        ST_USER,
        ST_REF
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sdram_refresh_ticker.sv
module sdram_refresh_ticker #(
    parameter int INTERVAL = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_d = 1'b0;
        if (en) begin
            if (cnt_q == CW'(INTERVAL - 1)) begin
                cnt_d  = '0;
                tick_d = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/sdram_owed_counter.sv
module sdram_owed_counter #(
    parameter int MAX_OWED = 8,
    localparam int OW = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [OW-1:0] owed
);
    logic [OW-1:0] owed_d, owed_q;
    logic          can_dec, can_inc;

    always_comb begin
        can_dec = dec && (owed_q != '0);
        can_inc = inc && (owed_q != OW'(MAX_OWED) || can_dec);
        owed_d  = owed_q;
        if (can_inc && !can_dec)      owed_d = owed_q + 1'b1;
        else if (can_dec && !can_inc) owed_d = owed_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else        owed_q <= owed_d;
    end

    assign owed = owed_q;
endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
    import sdram_seq_pkg::*;
#(
    parameter int       CLK_MHZ          = 100,
    parameter int       T_POWERUP_US     = 200,
    parameter int       T_RP_NS          = 20,
    parameter int       T_RFC_NS         = 70,
    parameter int       T_MRD_CLK        = 2,
    parameter int       REFRESH_ROWS     = 4096,
    parameter int       REFRESH_MS       = 64,
    parameter int       INIT_REFRESHES   = 2,
    parameter int       MAX_OWED         = 8,
    parameter int       ADDR_W           = 12,
    parameter int       BA_W             = 2,
    parameter int       DQM_W            = 2,
    parameter logic [2:0] BURST_LEN_CODE = 3'd3,
    parameter logic     BURST_INTERLEAVE = 1'b0,
    parameter int       CAS_LATENCY      = 3,
    parameter logic     WRITE_SINGLE     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_req,
    input  logic              usr_busy,
    output logic              usr_gnt,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);
    localparam int POWERUP_CYC  = T_POWERUP_US * CLK_MHZ;
    localparam int RP_CYC       = (T_RP_NS * CLK_MHZ + 999) / 1000;
    localparam int RFC_CYC      = (T_RFC_NS * CLK_MHZ + 999) / 1000;
    localparam int REF_INTERVAL = (REFRESH_MS * 1000 * CLK_MHZ) / REFRESH_ROWS;
    localparam int WAIT_MAX     = (POWERUP_CYC > RFC_CYC) ? POWERUP_CYC : RFC_CYC;
    localparam int WW           = $clog2(WAIT_MAX + 1);
    localparam int IRW          = $clog2(INIT_REFRESHES + 1);
    localparam int OWED_W       = $clog2(MAX_OWED + 1);
    localparam int AP_BIT       = 10;

    typedef struct packed {
        seq_state_t        state;
        logic [WW-1:0]     wait_cnt;
        logic [IRW-1:0]    init_left;
        sd_cmd_t           cmd;
        logic [ADDR_W-1:0] addr;
        logic              gnt;
        logic              done;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    logic              tick;
    logic              ref_dec;
    logic [OWED_W-1:0] owed_q;
    logic [ADDR_W-1:0] mode_word;

    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = BURST_LEN_CODE;
        mode_word[3]   = BURST_INTERLEAVE;
        mode_word[6:4] = 3'(CAS_LATENCY);
        mode_word[9]   = WRITE_SINGLE;
    end

    sdram_refresh_ticker #(.INTERVAL(REF_INTERVAL)) i_ticker (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (r_q.done),
        .tick (tick)
    );

    sdram_owed_counter #(.MAX_OWED(MAX_OWED)) i_owed (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (tick),
        .dec  (ref_dec),
        .owed (owed_q)
    );

    always_comb begin
        r_d     = r_q;
        r_d.cmd = CMD_NOP;
        ref_dec = 1'b0;
        if (r_q.wait_cnt != '0) begin
            r_d.wait_cnt = r_q.wait_cnt - 1'b1;
        end else begin
            unique case (r_q.state)
                ST_PWR: r_d.state = ST_IPRE;
                ST_IPRE: begin
                    r_d.cmd          = CMD_PRE;
                    r_d.addr         = '0;
                    r_d.addr[AP_BIT] = 1'b1;
                    r_d.wait_cnt     = WW'(RP_CYC - 1);
                    r_d.init_left    = IRW'(INIT_REFRESHES);
                    r_d.state        = ST_IREF;
                end
                ST_IREF: begin
                    r_d.cmd       = CMD_REF;
                    r_d.addr      = '0;
                    r_d.wait_cnt  = WW'(RFC_CYC - 1);
                    r_d.init_left = r_q.init_left - 1'b1;
                    if (r_q.init_left == IRW'(1)) r_d.state = ST_IMRS;
                end
                ST_IMRS: begin
                    r_d.cmd      = CMD_MRS;
                    r_d.addr     = mode_word;
                    r_d.wait_cnt = WW'(T_MRD_CLK - 1);
                    r_d.state    = ST_SETTLE;
                end
                ST_SETTLE: begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
                ST_IDLE: begin
                    if (owed_q != '0) begin
                        r_d.cmd          = CMD_PRE;
                        r_d.addr         = '0;
                        r_d.addr[AP_BIT] = 1'b1;
                        r_d.wait_cnt     = WW'(RP_CYC - 1);
                        r_d.state        = ST_REF;
                    end else if (usr_req) begin
                        r_d.gnt   = 1'b1;
                        r_d.state = ST_USER;
                    end
                end
                ST_USER: begin
                    if (!usr_req || (owed_q != '0 && !usr_busy)) begin
                        r_d.gnt   = 1'b0;
                        r_d.state = ST_IDLE;
                    end
                end
                ST_REF: begin
                    r_d.cmd      = CMD_REF;
                    r_d.addr     = '0;
                    r_d.wait_cnt = WW'(RFC_CYC - 1);
                    ref_dec      = 1'b1;
                    if (owed_q <= OWED_W'(1)) r_d.state = ST_IDLE;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state     <= ST_PWR;
            r_q.wait_cnt  <= WW'(POWERUP_CYC - 1);
            r_q.init_left <= '0;
            r_q.cmd       <= CMD_NOP;
            r_q.addr      <= '0;
            r_q.gnt       <= 1'b0;
            r_q.done      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign usr_gnt   = r_q.gnt;
    assign sd_cke    = 1'b1;
    assign sd_cs_n   = r_q.cmd.cs_n;
    assign sd_ras_n  = r_q.cmd.ras_n;
    assign sd_cas_n  = r_q.cmd.cas_n;
    assign sd_we_n   = r_q.cmd.we_n;
    assign sd_addr   = r_q.addr;
    assign sd_ba     = '0;
    assign sd_dqm    = r_q.done ? '0 : '1;
    assign init_done = r_q.done;
endmodule

// File: rtl/sdram_init_refresh_chk.sv
module sdram_init_refresh_chk #(
    parameter int RP_CYC   = 2,
    parameter int RFC_CYC  = 7,
    parameter int MAX_OWED = 8,
    parameter int OWED_W   = 4,
    parameter int DQM_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usr_req,
    input logic              usr_busy,
    input logic              usr_gnt,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [DQM_W-1:0]  sd_dqm,
    input logic              init_done,
    input logic [OWED_W-1:0] owed
);
    logic [3:0] code;
    logic       is_nop, is_ref, is_pre, is_mrs;
    logic [7:0] since_ref_q, since_pre_q;

    assign code   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_nop = (code == 4'b0111);
    assign is_pre = (code == 4'b0010);
    assign is_ref = (code == 4'b0001);
    assign is_mrs = (code == 4'b0000);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref_q <= 8'hff;
            since_pre_q <= 8'hff;
        end else begin
            since_ref_q <= is_ref ? 8'd1 : (since_ref_q == 8'hff ? 8'hff : since_ref_q + 8'd1);
            since_pre_q <= is_pre ? 8'd1 : (since_pre_q == 8'hff ? 8'hff : since_pre_q + 8'd1);
        end
    end

    assert_init_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (sd_cke && (&sd_dqm)));

    assert_pre_to_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (since_pre_q >= 8'(RP_CYC)));

    assert_mrs_settle1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> is_nop);

    assert_mrs_settle2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_mrs, 2) && $past(rst_n, 2) |-> is_nop);

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_ref_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (since_ref_q >= 8'(RFC_CYC)));

    assert_owed_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OWED_W'(MAX_OWED));

    assert_grant_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usr_gnt) |-> (init_done && $past(owed) == '0));

    assert_grant_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_gnt && usr_req && usr_busy) |=> usr_gnt);

    assert_user_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        usr_gnt |-> is_nop);
endmodule

bind sdram_init_refresh sdram_init_refresh_chk #(
    .RP_CYC  (RP_CYC),
    .RFC_CYC (RFC_CYC),
    .MAX_OWED(MAX_OWED),
    .OWED_W  (OWED_W),
    .DQM_W   (DQM_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .usr_req  (usr_req),
    .usr_busy (usr_busy),
    .usr_gnt  (usr_gnt),
    .sd_cke   (sd_cke),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_dqm   (sd_dqm),
    .init_done(init_done),
    .owed     (owed_q)
);

// File: tb/test_sdram_init_refresh.sv
module test_sdram_init_refresh;
    localparam int ADDR_W    = 12;
    localparam int POWERUP   = 20000;
    localparam int RP        = 2;
    localparam int RFC       = 7;
    localparam int INTERVAL  = 1562;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              usr_req;
    logic              usr_busy;
    logic              usr_gnt;
    logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [1:0]        sd_ba;
    logic [1:0]        sd_dqm;
    logic              init_done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdram_init_refresh i_sdram_init_refresh (
        .clk(clk), .rst_n(rst_n), .usr_req(usr_req), .usr_busy(usr_busy),
        .usr_gnt(usr_gnt), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .sd_dqm(sd_dqm), .init_done(init_done)
    );

    function automatic logic [3:0] cmd_now();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cmd_now() == C_NOP, "R1 reset cmd", cmd_now(), C_NOP);
        chk(sd_cke && sd_dqm == 2'b11, "R1 reset cke/dqm", {sd_cke, sd_dqm}, 3'b111);
        chk(!init_done && !usr_gnt, "R9 reset done/gnt", {init_done, usr_gnt}, 0);
    endtask

    task automatic t_init();
        int n = 0;
        int gap;
        bit pins_ok = 1;
        bit gnt_seen = 0;
        usr_req = 1'b1;
        step();
        while (cmd_now() == C_NOP && n < POWERUP + 100) begin
            if (!(sd_cke && sd_dqm == 2'b11 && !init_done)) pins_ok = 0;
            if (usr_gnt) gnt_seen = 1;
            n++;
            step();
        end
        chk(pins_ok, "R1 pins during power-up", pins_ok, 1);
        chk(n >= POWERUP, "R1 power-up NOP cycles", n, POWERUP);
        chk(cmd_now() == C_PRE && sd_addr[10], "R2 precharge-all", {cmd_now(), sd_addr[10]}, {C_PRE, 1'b1});
        for (int i = 0; i < 2; i++) begin
            gap = 0;
            do begin step(); gap++; if (usr_gnt) gnt_seen = 1; end
            while (cmd_now() == C_NOP && gap < 50);
            chk(cmd_now() == C_REF, "R3 init refresh", cmd_now(), C_REF);
            chk(gap >= (i == 0 ? RP : RFC), "R3 init refresh spacing", gap, (i == 0 ? RP : RFC));
        end
        gap = 0;
        do begin step(); gap++; end while (cmd_now() == C_NOP && gap < 50);
        chk(cmd_now() == C_MRS, "R4 mode load cmd", cmd_now(), C_MRS);
        chk(gap >= RFC, "R3 refresh to mode load spacing", gap, RFC);
        chk(sd_addr == 12'h033 && sd_ba == 2'b00, "R4 mode word", {sd_ba, sd_addr}, 14'h033);
        step();
        chk(cmd_now() == C_NOP && !init_done, "R5 settle cycle 1", {cmd_now(), init_done}, {C_NOP, 1'b0});
        chk(!gnt_seen && !usr_gnt, "R9 no grant before init_done", gnt_seen, 0);
        usr_req = 1'b0;
        step();
        chk(cmd_now() == C_NOP && init_done, "R5 settle cycle 2", {cmd_now(), init_done}, {C_NOP, 1'b1});
        step();
        chk(init_done && !usr_gnt, "R5 done stays", {init_done, usr_gnt}, 2'b10);
    endtask

    task automatic t_grant();
        usr_req = 1'b1;
        step();
        chk(usr_gnt, "R9 grant one cycle after req", usr_gnt, 1);
        for (int i = 0; i < 4; i++) begin
            chk(cmd_now() == C_NOP, "R10 NOP while granted", cmd_now(), C_NOP);
            step();
        end
        usr_req = 1'b0;
        step();
        chk(!usr_gnt, "R11 grant drops after req", usr_gnt, 0);
    endtask

    task automatic t_periodic();
        int n = 0;
        int refs = 0;
        while (cmd_now() == C_NOP && n < INTERVAL + 100) begin step(); n++; end
        chk(cmd_now() == C_PRE && sd_addr[10], "R6 precharge before refresh", {cmd_now(), sd_addr[10]}, {C_PRE, 1'b1});
        n = 0;
        do begin step(); n++; end while (cmd_now() == C_NOP && n < 50);
        chk(cmd_now() == C_REF, "R6 periodic refresh", cmd_now(), C_REF);
        chk(n >= RP, "R7 precharge to refresh", n, RP);
        for (int i = 0; i < 200; i++) begin
            step();
            if (cmd_now() == C_REF) refs++;
        end
        chk(refs == 0, "R6 exactly one refresh per interval", refs, 0);
    endtask

    task automatic t_backlog();
        int bad = 0;
        int refs = 0;
        int pres = 0;
        int last = -100;
        int min_gap = 1000;
        int n = 0;
        usr_req  = 1'b1;
        usr_busy = 1'b1;
        step();
        chk(usr_gnt, "R9 grant for busy user", usr_gnt, 1);
        for (int i = 0; i < 9 * INTERVAL; i++) begin
            if (!usr_gnt || cmd_now() != C_NOP) bad++;
            step();
        end
        chk(bad == 0, "R9 R10 grant held and NOP while busy", bad, 0);
        usr_busy = 1'b0;
        step();
        chk(!usr_gnt, "R9 grant dropped with refresh owed", usr_gnt, 0);
        while (!usr_gnt && n < 400) begin
            if (cmd_now() == C_PRE) pres++;
            if (cmd_now() == C_REF) begin
                if (n - last < min_gap) min_gap = n - last;
                last = n;
                refs++;
            end
            step();
            n++;
        end
        chk(refs == 8, "R8 saturated backlog refresh count", refs, 8);
        chk(pres == 1, "R8 single precharge before backlog", pres, 1);
        chk(min_gap >= RFC, "R7 back-to-back refresh spacing", min_gap, RFC);
        chk(usr_gnt, "R9 grant returns after drain", usr_gnt, 1);
        usr_req = 1'b0;
        step();
        chk(!usr_gnt, "R11 grant released", usr_gnt, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        usr_req  = 1'b0;
        usr_busy = 1'b0;
        repeat (5) step();
        t_reset();
        rst_n = 1'b1;
        t_init();
        t_grant();
        t_periodic();
        t_backlog();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule